// File: doc/BRIEF.md
# Spreading-Code Generator with Half-Chip Second Arm

This block produces the spreading code for one satellite tracking channel. A programmable 25-bit phase accumulator adds a code-rate increment on every clock. Each carry out of the accumulator is a half-chip tick, so the tick rate is twice the chip rate. An increment of 0x016EA4A8 sets the nominal rate of twice 1.023 Mchip/s, and one increment step moves the tick rate by roughly 85 mHz.

Two Gold-code generators follow the tick. The prompt generator moves one chip on every second tick. The second generator moves on the ticks in between, so it runs half a chip ahead of prompt. The second arm output is chosen by a mode input. It can give the early chip, a late chip (the prompt chip held back by one tick), or half of the early-minus-late difference. A one-cycle dump pulse marks the end of every 1023-chip code period so that downstream integrators can latch their sums. A new satellite number or a new arm mode restarts the whole channel at code phase zero.

Top module: `gold_code_chan`

## Requirements
- R1: After reset, the code phase is zero, `prompt_chip` is 1, `dump` is 0 and the arm mode is early, so `arm_out` is 2'b11.
- R2: The accumulator adds `code_incr` modulo 2^25 on every clock, and a tick occurs in each clock whose addition carries out. Ticks alternate between early-advance and prompt-advance, starting with early after reset or restart, so prompt moves one chip every second tick.
- R3: Each generator uses G1 (stage 1 is fed with stage 3 XOR stage 10) and G2 (stage 1 is fed with the XOR of stages 2, 3, 6, 8, 9 and 10). Both registers start all ones, and each advance shifts stage n into stage n+1. The chip is G1 stage 10 XOR the two G2 stages chosen for the PRN, so the first ten chips of PRN 1 are 1100100000 (octal 1440).
- R4: `prn_sel` values 1 to 37 select the standard G2 stage pairs (PRN 1: stages 2,6; PRN 37: stages 4,10). Any other value selects the pair of PRN 1.
- R5: With `arm_mode` = 0 (early), `arm_out` is the early generator's chip, which is half a chip ahead of prompt. A chip of 0 is sent as 2'b01 (+1) and a chip of 1 as 2'b11 (−1).
- R6: With `arm_mode` = 1 (late), `arm_out` is the prompt chip as it was before the latest tick, which puts it half a chip behind prompt. A restart sets this value to 1. It uses the same ±1 encoding.
- R7: With `arm_mode` = 2 or 3 (early-minus-late), `arm_out` is (early − late)/2 in the ±1 chip sense. The output is 2'b00 when the two chips agree, 2'b01 when early is 0 and late is 1, and 2'b11 when early is 1 and late is 0.
- R8: `dump` is high for exactly one cycle, in the cycle after the clock edge at which prompt moves from chip 1022 back to chip 0. It occurs once per 1023 prompt chips.
- R9: If `prn_sel` or `arm_mode` differs from the value in use, the next clock edge adopts the new value and restarts the channel. The accumulator is cleared, both generators go back to all ones, the tick parity goes back to early, the late chip is set to 1 and the code phase returns to zero.
- R10: A change of `code_incr` alone only changes the tick rate. It does not restart the channel or disturb the code phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_incr | input | 25 | Code-rate accumulator increment |
| prn_sel | input | 6 | Satellite code number |
| arm_mode | input | 2 | Second arm: 0 early, 1 late, 2/3 early-minus-late |
| prompt_chip | output | 1 | Current prompt chip |
| arm_out | output | 2 | Second arm value, two's complement (+1, 0, −1) |
| dump | output | 1 | One-cycle pulse at each code epoch |

## Verification
The bench builds the block with its default parameters: a 25-bit accumulator and a 1023-chip period. It drives increments near full scale so that a full code epoch, and therefore two dump pulses, fall within a few thousand cycles. An increment of exactly half of full scale gives a fixed four-cycle chip, and the first chips of a known code can be read directly from that. Irregular increments and the nominal increment exercise uneven tick spacing, and PRN values 0 and 50 reach the out-of-range fallback.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  localparam int GEN_W    = 10;
  localparam int CODE_LEN = 1023;
  localparam int PRN_W    = 6;

  typedef enum logic [1:0] {
    ARM_EARLY = 2'd0,
    ARM_LATE  = 2'd1,
    ARM_EML   = 2'd2,
    ARM_EML2  = 2'd3
  } arm_mode_t;

  typedef struct packed {
    logic [GEN_W-1:0] g1;
    logic [GEN_W-1:0] g2;
  } gen_state_t;

  // returns {first G2 stage, second G2 stage}, stages numbered 1..10
  function automatic logic [7:0] tap_pair(input logic [PRN_W-1:0] prn);
    logic [7:0] t;
    case (prn)
      6'd2:  t = {4'd3, 4'd7};   6'd3:  t = {4'd4, 4'd8};   6'd4:  t = {4'd5, 4'd9};
      6'd5:  t = {4'd1, 4'd9};   6'd6:  t = {4'd2, 4'd10};  6'd7:  t = {4'd1, 4'd8};
      6'd8:  t = {4'd2, 4'd9};   6'd9:  t = {4'd3, 4'd10};  6'd10: t = {4'd2, 4'd3};
      6'd11: t = {4'd3, 4'd4};   6'd12: t = {4'd5, 4'd6};   6'd13: t = {4'd6, 4'd7};
      6'd14: t = {4'd7, 4'd8};   6'd15: t = {4'd8, 4'd9};   6'd16: t = {4'd9, 4'd10};
      6'd17: t = {4'd1, 4'd4};   6'd18: t = {4'd2, 4'd5};   6'd19: t = {4'd3, 4'd6};
      6'd20: t = {4'd4, 4'd7};   6'd21: t = {4'd5, 4'd8};   6'd22: t = {4'd6, 4'd9};
      6'd23: t = {4'd1, 4'd3};   6'd24: t = {4'd4, 4'd6};   6'd25: t = {4'd5, 4'd7};
      6'd26: t = {4'd6, 4'd8};   6'd27: t = {4'd7, 4'd9};   6'd28: t = {4'd8, 4'd10};
      6'd29: t = {4'd1, 4'd6};   6'd30: t = {4'd2, 4'd7};   6'd31: t = {4'd3, 4'd8};
      6'd32: t = {4'd4, 4'd9};   6'd33: t = {4'd5, 4'd10};  6'd34: t = {4'd4, 4'd10};
      6'd35: t = {4'd1, 4'd7};   6'd36: t = {4'd2, 4'd8};   6'd37: t = {4'd4, 4'd10};
      default: t = {4'd2, 4'd6};  // PRN 1 and every unlisted value
    endcase
    return t;
  endfunction

  // bit k holds stage k+1; a step shifts stage n into stage n+1
  function automatic logic [GEN_W-1:0] g1_step(input logic [GEN_W-1:0] s);
    return {s[GEN_W-2:0], s[2] ^ s[9]};
  endfunction

  function automatic logic [GEN_W-1:0] g2_step(input logic [GEN_W-1:0] s);
    return {s[GEN_W-2:0], s[1] ^ s[2] ^ s[5] ^ s[7] ^ s[8] ^ s[9]};
  endfunction

  function automatic logic chip_of(input gen_state_t st, input logic [7:0] taps);
    logic [3:0] ia;
    logic [3:0] ib;
    ia = taps[7:4] - 4'd1;
    ib = taps[3:0] - 4'd1;
    return st.g1[GEN_W-1] ^ st.g2[ia] ^ st.g2[ib];
  endfunction

  // chip 0 -> +1, chip 1 -> -1, two's complement in two bits
  function automatic logic [1:0] chip_sgn(input logic c);
    return c ? 2'b11 : 2'b01;
  endfunction

  function automatic logic [1:0] eml_val(input logic e, input logic l);
    if (e == l) return 2'b00;
    return e ? 2'b11 : 2'b01;
  endfunction
endpackage

// File: rtl/gcc_nco.sv
module gcc_nco #(
  parameter int ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ACC_W-1:0] incr,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum_w;

  assign sum_w = {1'b0, acc_q} + {1'b0, incr};
  assign tick  = sum_w[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= sum_w[ACC_W-1:0];
  end

  // a carry leaves a residue smaller than the increment that caused it
  assert_acc_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (acc_q < $past(incr)));
endmodule

// File: rtl/gcc_gen.sv
module gcc_gen
  import gcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  input  logic [7:0] taps,
  output logic       chip,
  output gen_state_t state
);
  gen_state_t state_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      state_q.g1 <= '1;
      state_q.g2 <= '1;
    end else if (adv) begin
      state_q.g1 <= g1_step(state_q.g1);
      state_q.g2 <= g2_step(state_q.g2);
    end
  end

  assign chip  = chip_of(state_q, taps);
  assign state = state_q;

  assert_lfsr_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q.g1 != '0) && (state_q.g2 != '0));
endmodule

// File: rtl/gcc_epoch.sv
module gcc_epoch #(
  parameter int LEN = 1023,
  localparam int IDX_W = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             dump
);
  logic [IDX_W-1:0] idx_q;
  logic             dump_q;
  logic             last_w;

  assign last_w = (idx_q == IDX_W'(LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      idx_q  <= '0;
      dump_q <= 1'b0;
    end else begin
      dump_q <= adv && last_w;
      if (adv) idx_q <= last_w ? '0 : idx_q + 1'b1;
    end
  end

  assign idx  = idx_q;
  assign dump = dump_q;

  assert_dump_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dump_q |=> !dump_q);
endmodule

// File: rtl/gold_code_chan.sv
module gold_code_chan
  import gcc_pkg::*;
#(
  parameter int ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] code_incr,
  input  logic [5:0]       prn_sel,
  input  logic [1:0]       arm_mode,
  output logic             prompt_chip,
  output logic [1:0]       arm_out,
  output logic             dump
);
  localparam int IDX_W = $clog2(CODE_LEN);

  logic [5:0]       prn_q;
  arm_mode_t        mode_q;
  logic             restart;
  logic             tick;
  logic             ph_q;
  logic             late_q;
  logic             adv_p;
  logic             adv_e;
  logic             early_chip;
  logic [7:0]       taps_w;
  logic [IDX_W-1:0] chip_idx;
  gen_state_t       p_state;
  gen_state_t       e_state;

  assign restart = (prn_sel != prn_q) || (arm_mode_t'(arm_mode) != mode_q);
  assign taps_w  = tap_pair(prn_q);
  assign adv_p   = tick && ph_q;
  assign adv_e   = tick && !ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prn_q  <= 6'd1;
      mode_q <= ARM_EARLY;
      ph_q   <= 1'b0;
      late_q <= 1'b1;
    end else if (restart) begin
      prn_q  <= prn_sel;
      mode_q <= arm_mode_t'(arm_mode);
      ph_q   <= 1'b0;
      late_q <= 1'b1;
    end else if (tick) begin
      ph_q   <= ~ph_q;
      late_q <= prompt_chip;
    end
  end

  gcc_nco #(.ACC_W(ACC_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .clr(restart), .incr(code_incr), .tick(tick)
  );

  gcc_gen u_prompt (
    .clk(clk), .rst_n(rst_n), .clr(restart), .adv(adv_p), .taps(taps_w),
    .chip(prompt_chip), .state(p_state)
  );

  gcc_gen u_early (
    .clk(clk), .rst_n(rst_n), .clr(restart), .adv(adv_e), .taps(taps_w),
    .chip(early_chip), .state(e_state)
  );

  gcc_epoch #(.LEN(CODE_LEN)) u_epoch (
    .clk(clk), .rst_n(rst_n), .clr(restart), .adv(adv_p),
    .idx(chip_idx), .dump(dump)
  );

  always_comb begin
    case (mode_q)
      ARM_EARLY: arm_out = chip_sgn(early_chip);
      ARM_LATE:  arm_out = chip_sgn(late_q);
      default:   arm_out = eml_val(early_chip, late_q);
    endcase
  end

  // on even tick parity the early arm has caught back up with prompt
  assert_half_chip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_q |-> (e_state == p_state));

  assert_epoch_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dump |-> ((p_state == '1) && (chip_idx == '0)));

  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ((chip_idx == '0) && !dump && prompt_chip));

  assert_arm_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arm_out != 2'b10);
endmodule

// File: tb/sim_gold_code_chan.sv
module sim_gold_code_chan;
  localparam int ACC_W = 25;
  localparam longint MOD = 64'd1 << ACC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ACC_W-1:0] code_incr = 25'h1000000;
  logic [5:0] prn_sel = 6'd1;
  logic [1:0] arm_mode = 2'd0;
  logic prompt_chip;
  logic [1:0] arm_out;
  logic dump;

  always #5 clk = ~clk;

  gold_code_chan #(.ACC_W(ACC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .code_incr(code_incr), .prn_sel(prn_sel),
    .arm_mode(arm_mode), .prompt_chip(prompt_chip), .arm_out(arm_out), .dump(dump)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int tap_a[38] = '{0, 2,3,4,5,1,2,1,2,3,2, 3,5,6,7,8,9,1,2,3,4,
                    5,6,1,4,5,6,7,8,1,2, 3,4,5,4,1,2,4};
  int tap_b[38] = '{0, 6,7,8,9,9,10,8,9,10,3, 4,6,7,8,9,10,4,5,6,7,
                    8,9,3,6,7,8,9,10,6,7, 8,9,10,10,7,8,10};

  bit seq[1023];
  longint acc_m;
  int ph_m, p_m, e_m, prn_m, mode_m;
  bit late_m, dump_m;
  bit cap_on = 0;
  bit [9:0] cap;
  int dump_seen = 0;

  function automatic void build_seq(int prn);
    int k;
    bit g1[10];
    bit g2[10];
    bit f1, f2;
    k = (prn >= 1 && prn <= 37) ? prn : 1;
    for (int j = 0; j < 10; j++) begin g1[j] = 1; g2[j] = 1; end
    for (int i = 0; i < 1023; i++) begin
      seq[i] = g1[9] ^ g2[tap_a[k]-1] ^ g2[tap_b[k]-1];
      f1 = g1[2] ^ g1[9];
      f2 = g2[1] ^ g2[2] ^ g2[5] ^ g2[7] ^ g2[8] ^ g2[9];
      for (int j = 9; j > 0; j--) begin g1[j] = g1[j-1]; g2[j] = g2[j-1]; end
      g1[0] = f1;
      g2[0] = f2;
    end
  endfunction

  function automatic logic [1:0] pm(bit c);
    return c ? 2'b11 : 2'b01;
  endfunction

  task automatic clear_model(int prn, int mode);
    acc_m = 0; ph_m = 0; p_m = 0; e_m = 0; late_m = 1; dump_m = 0;
    prn_m = prn; mode_m = mode;
    build_seq(prn);
  endtask

  task automatic model_step();
    longint s;
    if (!rst_n) clear_model(1, 0);
    else if (int'(prn_sel) != prn_m || int'(arm_mode) != mode_m)
      clear_model(int'(prn_sel), int'(arm_mode));
    else begin
      s = acc_m + longint'(code_incr);
      dump_m = 0;
      acc_m = s % MOD;
      if (s >= MOD) begin
        late_m = seq[p_m];
        if (ph_m == 0) e_m = (e_m + 1) % 1023;
        else begin
          if (p_m == 1022) dump_m = 1;
          p_m = (p_m + 1) % 1023;
        end
        ph_m = 1 - ph_m;
      end
    end
  endtask

  task automatic compare(string req);
    logic [1:0] ea;
    logic ep;
    ep = seq[p_m];
    if (mode_m == 0) ea = pm(seq[e_m]);
    else if (mode_m == 1) ea = pm(late_m);
    else ea = (seq[e_m] == late_m) ? 2'b00 : (seq[e_m] ? 2'b11 : 2'b01);
    tests++;
    if (prompt_chip !== ep || arm_out !== ea || dump !== dump_m) begin
      fails++;
      $display("FAIL %s: prompt/arm/dump act %b/%b/%b exp %b/%b/%b at t=%0t",
               req, prompt_chip, arm_out, dump, ep, ea, dump_m, $time);
    end
    if (cap_on && p_m < 10) cap[9 - p_m] = prompt_chip;
    if (dump === 1'b1) dump_seen++;
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(req);
    end
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s act %0d exp %0d", req, what, act, exp);
    end
  endtask

  initial begin
    clear_model(1, 0);
    run(3, "R1");
    rst_n = 1'b1;
    run(1, "R1");
    check(prompt_chip === 1'b1 && dump === 1'b0 && arm_out === 2'b11, "R1",
          "reset prompt/dump/arm", {prompt_chip, dump, arm_out}, 4'b1011);

    // R3: half-scale increment, one chip per four cycles; read PRN 1 head
    cap_on = 1;
    run(60, "R3");
    cap_on = 0;
    check(cap == 10'b1100100000, "R3", "PRN1 first ten chips", cap, 10'b1100100000);

    // R2: irregular tick spacing
    code_incr = 25'h1000000 + 25'd777;
    run(3000, "R2");

    prn_sel = 6'd5;  run(2000, "R5");
    arm_mode = 2'd1; run(2000, "R6");
    arm_mode = 2'd2; run(2000, "R7");
    arm_mode = 2'd3; run(1000, "R7");

    prn_sel = 6'd37; run(1500, "R4");
    prn_sel = 6'd0;  run(1500, "R4");
    prn_sel = 6'd50; run(1500, "R4");

    // R9: restart mid-code
    prn_sel = 6'd12; arm_mode = 2'd0;
    run(1, "R9");
    check(prompt_chip === 1'b1 && dump === 1'b0 && arm_out === 2'b11, "R9",
          "restart prompt/dump/arm", {prompt_chip, dump, arm_out}, 4'b1011);
    run(1500, "R9");

    // R8: near full-scale increment, two epochs
    code_incr = 25'h1FFFFFF; prn_sel = 6'd20;
    dump_seen = 0;
    run(4300, "R8");
    check(dump_seen == 2, "R8", "dump pulses in 4300 cycles", dump_seen, 2);

    // R10: rate change only, no restart
    code_incr = 25'h016EA4A8;
    run(3000, "R10");
    code_incr = 25'h0ABCDEF;
    run(2000, "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: act running exp finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule